// File: doc/BRIEF.md
# Burst Column Order Generator

This block turns a single memory column command into the ordered list of column offsets that one eight-slot DRAM burst walks through. One cycle per slot, it reports which offset inside the aligned group of eight columns is being moved. It also says whether the data driver should be on for that slot. It handles both wrap orders: sequential order, which wraps inside each four-column half, and interleaved order, which is the start offset XORed with the slot number. It also handles both burst sizes, a full eight-beat burst and a burst chopped to four beats.

The burst size is set by a length mode. The mode can fix every burst at eight beats, fix every burst at four beats, or take the size from a per-command select bit. Reads and writes start differently. A read starts at the requested offset. A full write always starts at zero. A chopped write keeps only the top bit of the start offset.

A command can arrive while a burst is still running. In that case it is not taken, and `busy` stays high. The source must hold the command until `busy` drops. `busy` drops on the last slot, so the next burst can follow with no idle cycle.

Top module: `burst_seq_top`

## Requirements
- R1: While reset is asserted, and while no burst is running, `beatValid`, `driveEn` and `busy` are 0 and `beatOffset` is 0.
- R2: A command is taken on a rising clock edge where `cmdValid` is 1 and `busy` is 0. From the next cycle, `beatValid` is 1 for exactly eight consecutive cycles (slots 0 to 7). After that it returns to 0 unless another command was taken.
- R3: For a read with `interleave` = 0, the offset of slot s is formed as follows, where c is `colLow`. Bit 2 is c[2] XOR s[2]. Bits 1:0 are (c[1:0] + s[1:0]) mod 4. For example, start 5 gives 5,6,7,4,1,2,3,0.
- R4: For a read with `interleave` = 1, the offset of slot s is c XOR s. For example, start 5 gives 5,4,7,6,1,0,3,2.
- R5: An eight-beat write produces 0,1,...,7 whatever the values of `colLow` and `interleave`.
- R6: A chopped read produces slots 0 to 3 as in R3 or R4. In slots 4 to 7, `driveEn` is 0 and `beatOffset` is 0, while `beatValid` stays 1.
- R7: A chopped write ignores c[1:0]. It uses the start value {c[2],2'b00}, so it produces 0,1,2,3 or 4,5,6,7 in either order type. Slots 4 to 7 are blank, as in R6.
- R8: The `lenMode` encoding is 0 for fixed eight beats and 1 for fixed chop-four. Values 2 and 3 mean per-command selection, where `lenSel` = 1 gives eight beats and `lenSel` = 0 gives a chop. All command fields are sampled only on the cycle the command is taken.
- R9: `busy` is 1 while a burst is in slots 0 to 6, and 0 in slot 7 and when idle. A command offered while `busy` is 1 leaves the running burst unchanged. If it is held, it is taken in slot 7, and its slot 0 follows directly after slot 7.
- R10: For an eight-beat burst, `driveEn` is 1 in all eight slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| cmdValid | input | 1 | Column command offered this cycle |
| cmdIsWrite | input | 1 | 1 for a write command, 0 for a read |
| colLow | input | 3 | Low column address bits giving the start offset |
| interleave | input | 1 | 0 for sequential order, 1 for interleaved order |
| lenMode | input | 2 | Burst length mode (see R8) |
| lenSel | input | 1 | Per-command length select: 1 for eight beats, 0 for chop |
| beatValid | output | 1 | A burst slot is occupied this cycle |
| beatOffset | output | 3 | Column offset for this slot |
| driveEn | output | 1 | Data is driven in this slot (0 in chopped tail slots) |
| busy | output | 1 | A new command would not be taken this cycle |

## Verification
The hardest case to reach is a command that arrives partway through a running burst. That command must be held off without disturbing the running offsets, and then taken on the final slot with no gap between bursts. The stimulus starts a burst, raises a second command in its third slot, and keeps it held through slot 7. Meanwhile it checks `busy` and the first burst's offsets. It then expects the second burst's first offset on the very next cycle. The per-command length bit and the write flag are changed right after each command is taken, which shows that they are sampled only on the command cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  parameter int COL_W = 3;

  typedef enum logic [1:0] {
    LEN_FIXED8  = 2'd0,
    LEN_FIXED4  = 2'd1,
    LEN_PERCMD  = 2'd2,
    LEN_PERCMD2 = 2'd3
  } lenMode_e;

  typedef struct packed {
    logic             load;
    logic             active;
    logic [COL_W-1:0] slot;
  } seqStrobe_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int SLOT_W = COL_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  output seqStrobe_t strobe,
  output logic       busy
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = {SLOT_W{1'b1}};

  logic              active;
  logic [SLOT_W-1:0] slot;
  logic              load;

  assign busy = active && (slot != LAST_SLOT);
  assign load = cmdValid && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      slot   <= '0;
    end else if (load) begin
      active <= 1'b1;
      slot   <= '0;
    end else if (active) begin
      if (slot == LAST_SLOT) begin
        active <= 1'b0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load   = load;
    strobe.active = active;
    strobe.slot   = slot;
  end

  // R2: a taken command opens slot 0 on the next cycle
  p_start_slot0_r2: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (active && slot == '0));

  // R2: the last slot closes the burst when no command follows
  p_burst_ends_r2: assert property (@(posedge clk) disable iff (!rstN)
    (active && slot == LAST_SLOT && !cmdValid) |=> !active);

  // R9: while busy, the running burst just advances
  p_busy_advances_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (active && slot == $past(slot) + 1'b1));
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int OFF_W = COL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             cmdIsWrite,
  input  logic [OFF_W-1:0] colLow,
  input  logic             interleave,
  input  logic [1:0]       lenMode,
  input  logic             lenSel,
  output logic             beatValid,
  output logic [OFF_W-1:0] beatOffset,
  output logic             driveEn
);
  localparam int HALF_W = OFF_W - 1;

  logic [OFF_W-1:0]  startR;
  logic              ilR;
  logic              chopR;
  logic              chopNow;
  logic [OFF_W-1:0]  startNow;
  logic [HALF_W-1:0] seqLow;
  logic [OFF_W-1:0]  seqOff;
  logic [OFF_W-1:0]  ilOff;
  logic              tailSlot;

  always_comb begin
    chopNow = (lenMode == LEN_FIXED4) || (lenMode[1] && !lenSel);
    if (!cmdIsWrite) begin
      startNow = colLow;
    end else if (chopNow) begin
      startNow = {colLow[OFF_W-1], {HALF_W{1'b0}}};
    end else begin
      startNow = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startR <= '0;
      ilR    <= 1'b0;
      chopR  <= 1'b0;
    end else if (strobe.load) begin
      startR <= startNow;
      ilR    <= interleave;
      chopR  <= chopNow;
    end
  end

  assign seqLow   = startR[HALF_W-1:0] + strobe.slot[HALF_W-1:0];
  assign seqOff   = {startR[OFF_W-1] ^ strobe.slot[OFF_W-1], seqLow};
  assign ilOff    = startR ^ strobe.slot;
  assign tailSlot = chopR && strobe.slot[OFF_W-1];

  assign beatValid  = strobe.active;
  assign driveEn    = strobe.active && !tailSlot;
  assign beatOffset = driveEn ? (ilR ? ilOff : seqOff) : '0;

  // R1: no occupied slot means a quiet output
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !beatValid |-> (!driveEn && beatOffset == '0));

  // R4: a read's first beat is the requested offset in either order
  p_read_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !cmdIsWrite) |=> (beatOffset == $past(colLow)));

  // R5: a fixed eight-beat write opens at offset zero
  p_write8_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && cmdIsWrite && lenMode == LEN_FIXED8) |=> (beatOffset == '0 && driveEn));
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdIsWrite,
  input  logic [2:0] colLow,
  input  logic       interleave,
  input  logic [1:0] lenMode,
  input  logic       lenSel,
  output logic       beatValid,
  output logic [2:0] beatOffset,
  output logic       driveEn,
  output logic       busy
);
  seqStrobe_t strobe;

  burst_seq_ctrl #(.SLOT_W(COL_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .strobe   (strobe),
    .busy     (busy)
  );

  burst_seq_dp #(.OFF_W(COL_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdIsWrite (cmdIsWrite),
    .colLow     (colLow),
    .interleave (interleave),
    .lenMode    (lenMode),
    .lenSel     (lenSel),
    .beatValid  (beatValid),
    .beatOffset (beatOffset),
    .driveEn    (driveEn)
  );
endmodule

// File: tb/sim_burst_seq_top.sv
module sim_burst_seq_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdIsWrite = 1'b0;
  logic [2:0] colLow = '0;
  logic       interleave = 1'b0;
  logic [1:0] lenMode = '0;
  logic       lenSel = 1'b0;
  logic       beatValid;
  logic [2:0] beatOffset;
  logic       driveEn;
  logic       busy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  burst_seq_top u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsWrite(cmdIsWrite),
    .colLow(colLow), .interleave(interleave), .lenMode(lenMode), .lenSel(lenSel),
    .beatValid(beatValid), .beatOffset(beatOffset), .driveEn(driveEn), .busy(busy)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Model taken from R3..R7
  function automatic int expOff(bit wr, int ca, bit il, bit chop, int s);
    int base;
    if (chop && s >= 4) return 0;
    base = wr ? (chop ? (ca & 4) : 0) : ca;
    if (il) return base ^ s;
    return ((((base >> 2) ^ (s >> 2)) & 1) << 2) | ((base + s) & 3);
  endfunction

  task automatic issue(bit wr, int ca, bit il, int mode, bit sel);
    @(negedge clk);
    cmdValid = 1'b1; cmdIsWrite = wr; colLow = ca[2:0];
    interleave = il; lenMode = mode[1:0]; lenSel = sel;
    @(negedge clk);
    cmdValid = 1'b0; cmdIsWrite = ~wr; colLow = ~ca[2:0];
    interleave = ~il; lenMode = 2'd1; lenSel = ~sel;
  endtask

  // Called at the negedge showing slot 0; returns at slot 7
  task automatic expectList(string req, int e[8], bit chop);
    for (int i = 0; i < 8; i++) begin
      check({req, " valid"}, int'(beatValid), 1);
      check({req, " offset"}, int'(beatOffset), e[i]);
      check({req, " drive R6 R10"}, int'(driveEn), (chop && i >= 4) ? 0 : 1);
      check({req, " busy R9"}, int'(busy), (i < 7) ? 1 : 0);
      if (i < 7) @(negedge clk);
    end
  endtask

  task automatic doBurst(string req, bit wr, int ca, bit il, int mode, bit sel, bit chop);
    int e[8];
    for (int i = 0; i < 8; i++) e[i] = expOff(wr, ca, il, chop, i);
    issue(wr, ca, il, mode, sel);
    expectList(req, e, chop);
    @(negedge clk);
    check({req, " end R2"}, int'(beatValid), 0);
    check({req, " idle R1"}, int'(driveEn) + int'(busy) + int'(beatOffset), 0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(beatValid), 0);
    check("R1 drive in reset", int'(driveEn), 0);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 offset in reset", int'(beatOffset), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(beatValid), 0);
  endtask

  task automatic testSeqLiteral();
    int e[8] = '{5, 6, 7, 4, 1, 2, 3, 0};
    issue(1'b0, 5, 1'b0, 0, 1'b0);
    expectList("R3 seq start5", e, 1'b0);
    @(negedge clk);
    check("R2 after seq", int'(beatValid), 0);
  endtask

  task automatic testIlLiteral();
    int e[8] = '{5, 4, 7, 6, 1, 0, 3, 2};
    issue(1'b0, 5, 1'b1, 0, 1'b0);
    expectList("R4 il start5", e, 1'b0);
    @(negedge clk);
    check("R2 after il", int'(beatValid), 0);
  endtask

  task automatic testReads();
    for (int ca = 0; ca < 8; ca++) begin
      doBurst("R3 seq read", 1'b0, ca, 1'b0, 0, 1'b0, 1'b0);
      doBurst("R4 il read", 1'b0, ca, 1'b1, 0, 1'b0, 1'b0);
    end
  endtask

  task automatic testWrite8();
    doBurst("R5 write8 seq", 1'b1, 6, 1'b0, 0, 1'b0, 1'b0);
    doBurst("R5 write8 il", 1'b1, 3, 1'b1, 0, 1'b0, 1'b0);
  endtask

  task automatic testChopRead();
    doBurst("R6 chop read seq", 1'b0, 6, 1'b0, 1, 1'b1, 1'b1);
    doBurst("R6 chop read il", 1'b0, 1, 1'b1, 1, 1'b1, 1'b1);
  endtask

  task automatic testChopWrite();
    int hi[8] = '{4, 5, 6, 7, 0, 0, 0, 0};
    int lo[8] = '{0, 1, 2, 3, 0, 0, 0, 0};
    issue(1'b1, 6, 1'b0, 1, 1'b0);
    expectList("R7 chop write ca6", hi, 1'b1);
    issue(1'b1, 3, 1'b1, 1, 1'b0);
    expectList("R7 chop write ca3", lo, 1'b1);
    @(negedge clk);
  endtask

  task automatic testPerCmd();
    doBurst("R8 percmd long", 1'b0, 6, 1'b0, 2, 1'b1, 1'b0);
    doBurst("R8 percmd chop", 1'b0, 6, 1'b0, 2, 1'b0, 1'b1);
    doBurst("R8 mode3 chop", 1'b0, 2, 1'b1, 3, 1'b0, 1'b1);
    doBurst("R8 mode3 long write", 1'b1, 5, 1'b0, 3, 1'b1, 1'b0);
  endtask

  task automatic testBusy();
    int a[8];
    int b[8];
    for (int i = 0; i < 8; i++) begin
      a[i] = expOff(1'b0, 5, 1'b0, 1'b0, i);
      b[i] = expOff(1'b0, 3, 1'b1, 1'b0, i);
    end
    issue(1'b0, 5, 1'b0, 0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      if (i == 2) begin
        cmdValid = 1'b1; cmdIsWrite = 1'b0; colLow = 3'd3;
        interleave = 1'b1; lenMode = 2'd0; lenSel = 1'b0;
      end
      check("R9 held offset", int'(beatOffset), a[i]);
      check("R9 busy", int'(busy), (i < 7) ? 1 : 0);
      @(negedge clk);
    end
    cmdValid = 1'b0; colLow = 3'd0; interleave = 1'b0;
    expectList("R9 back to back", b, 1'b0);
    @(negedge clk);
    check("R9 end", int'(beatValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testSeqLiteral();
    testIlLiteral();
    testReads();
    testWrite8();
    testChopRead();
    testChopWrite();
    testPerCmd();
    testBusy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule